// File: doc/BRIEF.md
# Compressed table interpolation unit

This unit returns a value lying on the straight line between two neighbouring entries of a lookup table held in memory. The caller supplies the address of the first entry and an 8-bit fraction that places the lookup point along the segment. The unit then reads the first entry and the entry that follows it through a byte-wide memory read port. It takes the signed difference between the two entries and scales it by the fraction. The scaled difference is rounded and added to the first entry.

A mode pin selects the entry format for each operation. In byte mode the entries are single bytes and the result is 8 bits. In word mode the entries are 16-bit values stored high byte first, and the result is 16 bits.

Control is deliberately plain. A one-cycle `start` launches an operation, and `done` pulses once when the result is ready. There is no back-pressure and no queueing. A `start` that arrives while an operation is running is dropped, so the caller waits for `done` before launching the next operation. The memory port has no handshake, because every read returns its byte on the clock edge after the request.

Top module: `tbl_interp`

## Requirements
- R1: While reset is held and after it is released, `done` and `mem_rd_en` are 0 and `result` is 0 until the first operation completes.
- R2: In byte mode (`word_mode`=0) an operation issues exactly two reads, at `base_addr` and `base_addr`+1, in that order.
- R3: In word mode (`word_mode`=1) an operation issues exactly four reads, at `base_addr` through `base_addr`+3 in ascending order. The byte at the lower address of each pair is the high byte of the entry, so the first entry is {byte0, byte1} and the second entry is {byte2, byte3}.
- R4: When `frac` is 0x00, `result` equals the first entry.
- R5: In byte mode, let s and e be the two entries and d = (e - s) read as a signed 8-bit number. `result[7:0]` is s + floor((d*frac + 128) / 256) modulo 256, and `result[15:8]` is 0.
- R6: In word mode, let d = (e - s) read as a signed 16-bit number. `result` is s + floor((d*frac + 128) / 256) modulo 65536.
- R7: `done` is high for exactly one cycle per accepted operation. `result` changes only in the cycle where `done` is high, and it then holds until the next operation completes.
- R8: A `start` asserted before the current operation has raised `done` has no effect. It causes no reads, no extra `done` and no change to `result`.
- R9: The offset of `result` from the first entry, taken modulo the entry width, has the same sign as d and a magnitude no larger than |d|.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation; dropped while busy |
| base_addr | input | ADDR_W | Byte address of the first table entry |
| frac | input | 8 | Position in the segment, unsigned, radix point above bit 7 |
| word_mode | input | 1 | 0 selects byte entries, 1 selects 16-bit big-endian entries |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| result | output | 16 | Interpolated value; the upper byte is 0 in byte mode |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Two situations are hard to reach from the ports. The first is a `start` that lands while an operation is still fetching. The bench raises `start` again with a different address and fraction a few cycles into an operation. It then checks that the memory read sequence, the number of `done` pulses and the result all belong only to the first request. The second is a segment whose endpoints straddle the wrap point of the entry width, where the difference must be taken as signed. Entries such as 0xF0 followed by 0x10 in byte mode, or 0x7FFF followed by 0x8000 in word mode, test the modular sum. The extreme differences with fractions 0x00 and 0xFF test the rounding boundary.

// File: rtl/tbl_interp_pkg.sv
package tbl_interp_pkg;
  localparam int FRAC_W   = 8;
  localparam int BYTE_W   = 8;
  localparam int ENTRY_W  = 16;
  localparam int MAX_RDS  = 2 * (ENTRY_W / BYTE_W);
  localparam int CNT_W    = $clog2(MAX_RDS + 1);
  localparam int PROD_W   = (ENTRY_W + 1) + (FRAC_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_COMPUTE = 2'd2,
    ST_DONE    = 2'd3
  } interp_state_e;
endpackage

// File: rtl/tbl_interp_ctrl.sv
module tbl_interp_ctrl
  import tbl_interp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [FRAC_W-1:0]   frac,
  input  logic                word_mode,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [BYTE_W-1:0]   mem_rd_data,
  output logic [FRAC_W-1:0]   op_frac,
  output logic                op_word,
  output logic [ENTRY_W-1:0]  start_val,
  output logic [ENTRY_W-1:0]  end_val,
  output logic                load_result,
  output logic                done
);
  localparam int SHIFT_W = MAX_RDS * BYTE_W;

  interp_state_e       state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ADDR_W-1:0]   base_q;
  logic [SHIFT_W-1:0]  bytes_q;
  logic [CNT_W-1:0]    n_reads;

  assign n_reads = op_word ? CNT_W'(MAX_RDS) : CNT_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      op_frac <= '0;
      op_word <= 1'b0;
      bytes_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FETCH;
            cnt_q   <= '0;
            base_q  <= base_addr;
            op_frac <= frac;
            op_word <= word_mode;
            bytes_q <= '0;
          end
        end
        ST_FETCH: begin
          if (cnt_q != '0) begin
            bytes_q <= {bytes_q[SHIFT_W-BYTE_W-1:0], mem_rd_data};
          end
          if (cnt_q == n_reads) begin
            state_q <= ST_COMPUTE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_COMPUTE: state_q <= ST_DONE;
        ST_DONE:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = (state_q == ST_FETCH) && (cnt_q < n_reads);
  assign mem_addr    = base_q + ADDR_W'(cnt_q);
  assign load_result = (state_q == ST_COMPUTE);
  assign done        = (state_q == ST_DONE);

  generate
    if (ENTRY_W == 2 * BYTE_W) begin : g_two_byte_entries
      always_comb begin
        if (op_word) begin
          start_val = bytes_q[SHIFT_W-1 -: ENTRY_W];
          end_val   = bytes_q[ENTRY_W-1:0];
        end else begin
          start_val = {{(ENTRY_W-BYTE_W){1'b0}}, bytes_q[2*BYTE_W-1 -: BYTE_W]};
          end_val   = {{(ENTRY_W-BYTE_W){1'b0}}, bytes_q[BYTE_W-1:0]};
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tbl_interp_math.sv
module tbl_interp_math
  import tbl_interp_pkg::*;
(
  input  logic [ENTRY_W-1:0] start_val,
  input  logic [ENTRY_W-1:0] end_val,
  input  logic [FRAC_W-1:0]  frac,
  input  logic               word_mode,
  output logic [ENTRY_W-1:0] interp
);
  logic [ENTRY_W-1:0]       diff_raw;
  logic signed [ENTRY_W:0]  diff_s;
  logic signed [FRAC_W:0]   frac_s;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;
  logic [ENTRY_W-1:0]       sum;

  assign diff_raw = end_val - start_val;
  assign diff_s   = word_mode ? {diff_raw[ENTRY_W-1], diff_raw}
                              : {{(ENTRY_W-BYTE_W+1){diff_raw[BYTE_W-1]}}, diff_raw[BYTE_W-1:0]};
  assign frac_s   = {1'b0, frac};
  assign prod     = PROD_W'(diff_s) * PROD_W'(frac_s);
  assign rounded  = prod + PROD_W'(1 << (FRAC_W - 1));
  assign sum      = start_val + ENTRY_W'(rounded >>> FRAC_W);
  assign interp   = word_mode ? sum : {{(ENTRY_W-BYTE_W){1'b0}}, sum[BYTE_W-1:0]};
endmodule

// File: rtl/tbl_interp.sv
module tbl_interp
  import tbl_interp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [7:0]        frac,
  input  logic              word_mode,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic [15:0]       result,
  output logic              done
);
  logic [FRAC_W-1:0]  op_frac;
  logic               op_word;
  logic [ENTRY_W-1:0] start_val;
  logic [ENTRY_W-1:0] end_val;
  logic               load_result;
  logic [ENTRY_W-1:0] interp;

  tbl_interp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .base_addr   (base_addr),
    .frac        (frac),
    .word_mode   (word_mode),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .op_frac     (op_frac),
    .op_word     (op_word),
    .start_val   (start_val),
    .end_val     (end_val),
    .load_result (load_result),
    .done        (done)
  );

  tbl_interp_math u_math (
    .start_val (start_val),
    .end_val   (end_val),
    .frac      (op_frac),
    .word_mode (op_word),
    .interp    (interp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
    end else if (load_result) begin
      result <= interp;
    end
  end
endmodule

// File: rtl/tbl_interp_chk.sv
module tbl_interp_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       result,
  input logic [15:0]       start_val,
  input logic [15:0]       end_val,
  input logic              op_word
);
  logic [3:0]         rd_cnt;
  logic               in_range;
  logic signed [15:0] rel_w, dif_w;
  logic signed [7:0]  rel_b, dif_b;

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_cnt <= '0;
    else if (done)      rd_cnt <= '0;
    else if (mem_rd_en) rd_cnt <= rd_cnt + 1'b1;
  end

  always_comb begin
    rel_w = $signed(result - start_val);
    dif_w = $signed(end_val - start_val);
    rel_b = $signed(result[7:0] - start_val[7:0]);
    dif_b = $signed(end_val[7:0] - start_val[7:0]);
    if (op_word)
      in_range = (dif_w >= 0) ? (rel_w >= 0 && rel_w <= dif_w) : (rel_w <= 0 && rel_w >= dif_w);
    else
      in_range = (dif_b >= 0) ? (rel_b >= 0 && rel_b <= dif_b) : (rel_b <= 0 && rel_b >= dif_b);
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R7
  AST_IN_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_range); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R2
  AST_READ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_cnt == (op_word ? 4'd4 : 4'd2))); // R3
  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd_en); // R8
endmodule

bind tbl_interp tbl_interp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .mem_rd_en (mem_rd_en),
  .mem_addr  (mem_addr),
  .result    (result),
  .start_val (start_val),
  .end_val   (end_val),
  .op_word   (op_word)
);

// File: tb/test_tbl_interp.sv
module test_tbl_interp;
  localparam int AW = 16;

  typedef struct {
    logic [15:0]   exp;
    logic [AW-1:0] addr;
    bit            word;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [7:0]    frac = '0;
  logic          word_mode = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rd_data = '0;
  logic [15:0]   result;
  logic          done;

  logic [7:0]    mem [256];
  item_t         sb_q[$];
  logic [AW-1:0] rd_q[$];
  int            n_chk = 0, n_fail = 0;
  bit            finished = 0;
  logic [15:0]   last_exp = '0;

  always #10 clk = ~clk;

  tbl_interp #(.ADDR_W(AW)) i_tbl_interp (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .frac(frac),
    .word_mode(word_mode), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .result(result), .done(done)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr[7:0]];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [15:0] s, logic [15:0] e, logic [7:0] f, bit w);
    int sv, ev, d, r;
    if (w) begin
      sv = int'(s); ev = int'(e); d = ev - sv;
      if (d > 32767) d -= 65536;
      if (d < -32768) d += 65536;
    end else begin
      sv = int'(s[7:0]); ev = int'(e[7:0]); d = ev - sv;
      if (d > 127) d -= 256;
      if (d < -128) d += 256;
    end
    r = sv + ((d * int'(f) + 128) >>> 8);
    return w ? 16'(r) : {8'h00, 8'(r)};
  endfunction

  // monitor: read addresses and results
  always @(negedge clk) begin
    if (mem_rd_en) rd_q.push_back(mem_addr);
    if (done) begin
      if (sb_q.size() == 0) begin
        chk(0, "R8 unexpected done", 32'(result), 32'hx);
      end else begin
        item_t it;
        int n;
        it = sb_q.pop_front();
        n = it.word ? 4 : 2;
        chk(result == it.exp, it.tag, 32'(result), 32'(it.exp));
        chk(rd_q.size() == n, it.word ? "R3 read count" : "R2 read count",
            32'(rd_q.size()), 32'(n));
        for (int i = 0; i < n && i < rd_q.size(); i++)
          chk(rd_q[i] == AW'(it.addr + AW'(i)), it.word ? "R3 read addr" : "R2 read addr",
              32'(rd_q[i]), 32'(it.addr + AW'(i)));
      end
      rd_q.delete();
    end
  end

  task automatic run_op(input logic [AW-1:0] a, input logic [15:0] s, input logic [15:0] e,
                        input logic [7:0] f, input bit w, input string tag, input bit poke = 0);
    item_t it;
    if (w) begin
      mem[8'(a)] = s[15:8]; mem[8'(a+1)] = s[7:0];
      mem[8'(a+2)] = e[15:8]; mem[8'(a+3)] = e[7:0];
    end else begin
      mem[8'(a)] = s[7:0]; mem[8'(a+1)] = e[7:0];
    end
    it.exp = model(s, e, f, w); it.addr = a; it.word = w; it.tag = tag;
    sb_q.push_back(it);
    last_exp = it.exp;
    @(negedge clk);
    base_addr = a; frac = f; word_mode = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      base_addr = a + 16'h0040; frac = ~f; word_mode = ~w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, "R7 done single cycle", 32'(done), 32'h0);
    repeat (3) @(negedge clk);
    chk(result == last_exp && !done, "R7 result holds", 32'(result), 32'(last_exp));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd_en && result == 16'h0, "R1 during reset", 32'(result), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done, "R1 done low", 32'(done), 32'h0);
    chk(!mem_rd_en, "R1 no read", 32'(mem_rd_en), 32'h0);
    chk(result == 16'h0, "R1 result zero", 32'(result), 32'h0);

    run_op(16'h0010, 16'h0033, 16'h0033, 8'h80, 0, "R5 byte equal ends");
    run_op(16'h0020, 16'h0000, 16'h007F, 8'hFF, 0, "R5 byte max positive");
    run_op(16'h0030, 16'h0080, 16'h0000, 8'hFF, 0, "R5 byte max negative");
    run_op(16'h0040, 16'h0012, 16'h00F0, 8'h00, 0, "R4 byte frac zero");
    run_op(16'h0050, 16'h00F0, 16'h0010, 8'h80, 0, "R5 byte wrapped segment");
    run_op(16'h0060, 16'h0010, 16'h0011, 8'h80, 0, "R5 byte rounding half");
    run_op(16'h0070, 16'h0055, 16'h0054, 8'hFF, 0, "R9 byte small negative");
    run_op(16'h0080, 16'h1234, 16'h1234, 8'hC0, 1, "R6 word equal ends");
    run_op(16'h0090, 16'h0000, 16'h7FFF, 8'hFF, 1, "R6 word max positive");
    run_op(16'h00A0, 16'h8000, 16'h0000, 8'hFF, 1, "R6 word max negative");
    run_op(16'h00B0, 16'hBEEF, 16'h0102, 8'h00, 1, "R4 word frac zero");
    run_op(16'h00C0, 16'h7FFF, 16'h8000, 8'hFF, 1, "R6 word across sign");
    run_op(16'h00D0, 16'h1000, 16'h2000, 8'h40, 1, "R3 word big-endian");
    run_op(16'h00E0, 16'h0100, 16'h0080, 8'h81, 0, "R8 byte with start while busy", 1);
    run_op(16'h00F0, 16'hA000, 16'h9000, 8'h33, 1, "R8 word with start while busy", 1);
    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0, "R8 all results seen", 32'(sb_q.size()), 32'h0);
    chk(result == last_exp, "R8 result unchanged by dropped start", 32'(result), 32'(last_exp));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule